// File: doc/BRIEF.md
# Synchronized gated phase counter

This block measures how long an asynchronous phase-detector gate stays high, in ticks of a local 24 MHz reference clock. The gate is never used raw. It first passes through a two-flop synchronizer clocked by the reference clock. A rising edge of the synchronized gate restarts a running counter from zero. A falling edge copies the count into a held output register and raises a one-cycle valid strobe. Because only the synchronized gate touches the counter, every reported value is self-consistent. The only uncertainty is the expected one tick from synchronization. A raw strobe, by contrast, could freeze a half-updated multi-bit value.

A supervisor judges each capture against a window around the nominal locked count of 1024. A capture more than 30 ticks away raises a glitch flag together with its valid strobe. The first glitch opens a window that closes on the third one-second tick that follows it. If three glitches arrive before the window closes, the supervisor lights a sticky glitch LED and forces a hard clear of the counters. The counters are cleared in no other case and simply wrap.

Top module: `gate_phase_counter`

## Requirements
- R1: A gate held high for N consecutive reference-clock sampling edges (N at least 1) is reported as a count of N.
- R2: `count_valid` is high for exactly one cycle, seen after the third rising clock edge that follows the gate's fall. `count_out` changes only with that strobe or with the forced clear of R10, and holds its value otherwise.
- R3: The running count wraps modulo 2^16 and is never cleared on overflow. For example, a high time of 70000 ticks is reported as 4464.
- R4: `glitch_flag` is high in the same cycle as `count_valid` exactly when |count - 1024| > 30. So 1054 and 994 are in the window, and 1055 and 993 are glitches.
- R5: When a third glitch arrives while the window opened by the first glitch is still running, `glitch_led` rises in the same cycle as that capture's valid strobe.
- R6: The window closes on the third `pps_tick` that follows the first glitch. At that point the glitch count restarts from zero, so earlier glitches no longer count toward R5.
- R7: If a `pps_tick` that closes the window falls in the same cycle as a glitch capture, the window closes first. That glitch then counts as the first glitch of a new window.
- R8: `glitch_led` stays high once set and is cleared only by reset.
- R9: While reset is asserted and just after it is released, `count_out`, `count_valid`, `glitch_flag` and `glitch_led` are all 0.
- R10: The capture that lights the LED also restarts the glitch and seconds counts. One cycle after its valid strobe, the running counter and `count_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (24 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_async | input | 1 | Asynchronous phase-detector gate pulse |
| pps_tick | input | 1 | One-cycle pulse once per second, synchronous to clk |
| count_out | output | 16 | Last captured gate width in reference ticks |
| count_valid | output | 1 | One-cycle strobe when count_out is updated |
| glitch_flag | output | 1 | High with count_valid when the capture is outside the window |
| glitch_led | output | 1 | Sticky indicator of repeated glitches |

## Verification
Two events can meet in one clock cycle: a seconds tick that closes the glitch window, and a glitch capture. The bench provokes this by timing `pps_tick` so it is sampled on the same edge that registers the capture. It does this after two glitch-free ticks have followed a first glitch. The outcome is judged at the LED: under the close-first rule it must stay dark for that capture and the next, and light only on the third glitch of the new window. Outside this directed case, a bench model of the window tracks random widths and random ticks to predict the flag, the LED and the forced clear.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Distance between a captured count and the nominal value.
  function automatic int unsigned abs_gap(input int unsigned val, input int unsigned nom);
    return (val > nom) ? (val - nom) : (nom - val);
  endfunction

  // A capture is an outlier when it strays beyond the allowed distance.
  function automatic logic is_outlier(input int unsigned val, input int unsigned nom,
                                      input int unsigned lim);
    return abs_gap(val, nom) > lim;
  endfunction

endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] stg;
  logic              sync_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= 1'b0;
    else        stg[0] <= din_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= 1'b0;
      else        stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_d <= 1'b0;
    else        sync_d <= stg[STAGES-1];
  end

  assign rise = stg[STAGES-1] & ~sync_d;
  assign fall = ~stg[STAGES-1] & sync_d;
endmodule

// File: rtl/pc_gate_counter.sv
module pc_gate_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          clear,
  output logic [CW-1:0] run_cnt,
  output logic [CW-1:0] cap_val,
  output logic [CW-1:0] count_out,
  output logic          count_valid
);
  // The fall cycle is itself a high-time tick not yet added to run_cnt.
  assign cap_val = run_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (clear || rise) begin
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_out   <= '0;
      count_valid <= 1'b0;
    end else begin
      count_valid <= fall && !clear;
      if (clear)     count_out <= '0;
      else if (fall) count_out <= cap_val;
    end
  end
endmodule

// File: rtl/pc_supervisor.sv
module pc_supervisor
  import pc_pkg::*;
#(
  parameter int CW           = 16,
  parameter int NOMINAL      = 1024,
  parameter int LIMIT        = 30,
  parameter int GLITCH_LIMIT = 3,
  parameter int SEC_LIMIT    = 3,
  localparam int GW          = $clog2(GLITCH_LIMIT + 1),
  localparam int SW          = $clog2(SEC_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_fire,
  input  logic [CW-1:0] cap_val,
  input  logic          pps_tick,
  output logic          glitch_flag,
  output logic          glitch_led,
  output logic          hard_clear,
  output logic          led_set,
  output logic [GW-1:0] gcnt
);
  localparam logic [GW-1:0] G_TRIP = GW'(GLITCH_LIMIT);
  localparam logic [SW-1:0] S_LAST = SW'(SEC_LIMIT - 1);

  logic [SW-1:0] sec;
  logic          outlier;
  logic          active;
  logic          expire;
  logic [GW-1:0] base;
  logic [GW-1:0] nxt;

  always_comb begin
    outlier = cap_fire && is_outlier(int'(cap_val), NOMINAL, LIMIT);
    active  = (gcnt != '0);
    expire  = pps_tick && active && (sec == S_LAST);
    base    = expire ? '0 : gcnt;
    nxt     = base + GW'(outlier);
    led_set = outlier && (nxt == G_TRIP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glitch_flag <= 1'b0;
      glitch_led  <= 1'b0;
      hard_clear  <= 1'b0;
      gcnt        <= '0;
      sec         <= '0;
    end else begin
      glitch_flag <= outlier;
      hard_clear  <= led_set;
      if (led_set) glitch_led <= 1'b1;
      if (led_set) begin
        gcnt <= '0;
        sec  <= '0;
      end else begin
        gcnt <= nxt;
        if (base == '0)    sec <= '0;
        else if (pps_tick) sec <= sec + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gate_phase_counter.sv
module gate_phase_counter #(
  parameter int CW           = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int NOMINAL      = 1024,
  parameter int LIMIT        = 30,
  parameter int GLITCH_LIMIT = 3,
  parameter int SEC_LIMIT    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_async,
  input  logic          pps_tick,
  output logic [CW-1:0] count_out,
  output logic          count_valid,
  output logic          glitch_flag,
  output logic          glitch_led
);
  localparam int GW = $clog2(GLITCH_LIMIT + 1);

  // Named internal events, visible to the bound checker.
  logic          sync_rise;
  logic          sync_fall;
  logic          hard_clear;
  logic          led_set;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] cap_val;
  logic [GW-1:0] gcnt;

  pc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din_async(gate_async),
    .rise(sync_rise), .fall(sync_fall)
  );

  pc_gate_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise(sync_rise), .fall(sync_fall),
    .clear(hard_clear), .run_cnt(run_cnt), .cap_val(cap_val),
    .count_out(count_out), .count_valid(count_valid)
  );

  pc_supervisor #(
    .CW(CW), .NOMINAL(NOMINAL), .LIMIT(LIMIT),
    .GLITCH_LIMIT(GLITCH_LIMIT), .SEC_LIMIT(SEC_LIMIT)
  ) u_sup (
    .clk(clk), .rst_n(rst_n), .cap_fire(sync_fall), .cap_val(cap_val),
    .pps_tick(pps_tick), .glitch_flag(glitch_flag), .glitch_led(glitch_led),
    .hard_clear(hard_clear), .led_set(led_set), .gcnt(gcnt)
  );
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int CW           = 16,
  parameter int GLITCH_LIMIT = 3,
  localparam int GW          = $clog2(GLITCH_LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_rise,
  input logic          sync_fall,
  input logic          hard_clear,
  input logic          led_set,
  input logic [CW-1:0] run_cnt,
  input logic [GW-1:0] gcnt,
  input logic [CW-1:0] count_out,
  input logic          count_valid,
  input logic          glitch_flag,
  input logic          glitch_led
);
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (run_cnt == '0));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_rise && !hard_clear) |=> (run_cnt == CW'($past(run_cnt) + 1'b1)));

  p_valid_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fall && !hard_clear) |=> count_valid);

  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_valid |=> !count_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_valid && !$past(hard_clear)) |-> $stable(count_out));

  p_flag_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_flag |-> count_valid);

  p_led_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    led_set |=> (glitch_led && hard_clear && glitch_flag));

  p_gcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt < GW'(GLITCH_LIMIT));

  p_led_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_led |=> glitch_led);

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clear |=> (run_cnt == '0 && count_out == '0 && gcnt == '0));
endmodule

bind gate_phase_counter pc_checker #(.CW(CW), .GLITCH_LIMIT(GLITCH_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise), .sync_fall(sync_fall),
  .hard_clear(hard_clear), .led_set(led_set), .run_cnt(run_cnt), .gcnt(gcnt),
  .count_out(count_out), .count_valid(count_valid), .glitch_flag(glitch_flag),
  .glitch_led(glitch_led)
);

// File: tb/gate_phase_counter_test.sv
module gate_phase_counter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate_async = 1'b0;
  logic        pps_tick = 1'b0;
  logic [15:0] count_out;
  logic        count_valid;
  logic        glitch_flag;
  logic        glitch_led;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the glitch window.
  int m_g = 0;
  int m_s = 0;
  bit m_led = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_phase_counter uut (
    .clk(clk), .rst_n(rst_n), .gate_async(gate_async), .pps_tick(pps_tick),
    .count_out(count_out), .count_valid(count_valid),
    .glitch_flag(glitch_flag), .glitch_led(glitch_led)
  );

  function automatic int exp_count(input int w);
    return w % 65536;
  endfunction

  function automatic bit exp_glitch(input int c);
    int d;
    d = (c > 1024) ? c - 1024 : 1024 - c;
    return d > 30;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_tick();
    if (m_g != 0) begin
      if (m_s == 2) begin m_g = 0; m_s = 0; end
      else m_s++;
    end
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; gate_async = 1'b0; pps_tick = 1'b0;
    m_g = 0; m_s = 0; m_led = 0;
    repeat (3) @(negedge clk);
    check("R9", "valid in reset", int'(count_valid), 0);
    check("R9", "led in reset", int'(glitch_led), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "count after reset", int'(count_out), 0);
    check("R9", "flag after reset", int'(glitch_flag), 0);
  endtask

  task automatic tick();
    @(negedge clk) pps_tick = 1'b1;
    @(negedge clk) pps_tick = 1'b0;
    model_tick();
  endtask

  // One gate pulse of w ticks; optionally a pps tick on the capture edge.
  task automatic pulse(input int w, input bit tick_at_fall, input string req);
    int  ec;
    bit  eg;
    bit  clr;
    int  prev;
    prev = int'(count_out);
    ec = exp_count(w);
    eg = exp_glitch(ec);
    clr = 0;
    @(negedge clk) gate_async = 1'b1;
    repeat (w) @(negedge clk);
    gate_async = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2", "valid early", int'(count_valid), 0);
    check("R2", "count held before strobe", int'(count_out), prev);
    if (tick_at_fall) pps_tick = 1'b1;
    @(negedge clk);
    pps_tick = 1'b0;
    if (tick_at_fall) model_tick();
    if (eg) begin
      if (m_g == 0) m_s = 0;
      m_g++;
      if (m_g == 3) begin m_led = 1; clr = 1; m_g = 0; m_s = 0; end
    end
    check("R2", "valid strobe", int'(count_valid), 1);
    check((w > 65535) ? "R3" : "R1", "count", int'(count_out), ec);
    check("R4", "glitch flag", int'(glitch_flag), int'(eg));
    check(req, "led", int'(glitch_led), int'(m_led));
    @(negedge clk);
    check("R2", "valid one cycle", int'(count_valid), 0);
    check("R4", "flag one cycle", int'(glitch_flag), 0);
    check(clr ? "R10" : "R2", "count after strobe", int'(count_out), clr ? 0 : ec);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();

    // Directed widths, including window boundaries.
    pulse(1, 0, "R1");
    pulse(2, 0, "R1");
    pulse(1024, 0, "R1");
    pulse(1054, 0, "R4");
    pulse(1055, 0, "R4");
    pulse(994, 0, "R4");
    pulse(993, 0, "R4");

    // Random widths around the locked value with random ticks.
    do_reset();
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 40; i++) begin
      int w;
      w = 960 + int'($urandom % 130);
      pulse(w, ($urandom % 5) == 0, "R5");
      if (($urandom % 3) == 0) tick();
    end

    // Window expiry, then three glitches inside one window.
    do_reset();
    pulse(1100, 0, "R5");
    pulse(1100, 0, "R5");
    tick(); tick(); tick();
    pulse(1100, 0, "R6");
    pulse(1100, 0, "R6");
    tick();
    pulse(1100, 0, "R5");
    check("R5", "led lit", int'(glitch_led), 1);
    pulse(1024, 0, "R8");
    tick(); tick(); tick(); tick();
    pulse(1000, 0, "R8");
    check("R8", "led held", int'(glitch_led), 1);
    do_reset();
    check("R8", "led cleared by reset", int'(glitch_led), 0);

    // Tick closing the window in the same cycle as a glitch capture.
    pulse(1100, 0, "R7");
    tick(); tick();
    pulse(1100, 1, "R7");
    check("R7", "led after coincidence", int'(glitch_led), 0);
    pulse(1100, 0, "R7");
    check("R7", "led after second", int'(glitch_led), 0);
    pulse(1100, 0, "R7");
    check("R7", "led after third", int'(glitch_led), 1);

    // Counter wrap on a very long gate.
    pulse(70000, 0, "R3");

    do_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule